// File: doc/BRIEF.md
# Fuse Word Program and Sense Controller

This block sits between a simple single-cycle register bus and a small one-time-programmable fuse store. Software chooses one fuse word through an address field in a control register. It can then sense that word into a read-data register, or burn a 32-bit pattern into it. Burning is allowed only while a 16-bit unlock key is present in the control register. Every operation runs as three timed phases: setup, strobe and hold. The phase lengths come from a timing register and are counted in clock cycles.

The control register has a plain write view, a set view (OR) and a clear view (AND-NOT). The clear view is also the only way to reset the sticky error flag. The fuse store is modelled behaviourally: a burn ORs the pattern into the stored word, so a fuse bit that is 1 can never return to 0. The store is blank (all zero) after reset.

Top module: `fuse_word_ctrl`

Register map (word index on `bus_addr`): 0 control, 1 control-set, 2 control-clear, 3 timing, 4 sense trigger, 5 read data, 6 write data, 7 unused (reads 0). Control layout: [31:16] unlock key, [9] sticky error, [8] busy, [4:0] fuse address = bank*8 + word. Timing layout: [21:16] read strobe, [15:12] relax, [11:0] program strobe.

## Requirements
- R1: After reset, control reads 0x00000000, timing reads 0x00061014 (read strobe 6, relax 1, program strobe 20), and read data reads 0.
- R2: A write to control (index 0) loads the key from [31:16] and the address from [4:0]. Bits 8 and 9 cannot be set through index 0 or index 1. Index 1 ORs the written key and address bits into the register.
- R3: A write to index 2 clears every key and address bit that is 1 in the written word, and clears the sticky error flag when bit 9 is 1.
- R4: Timing (index 3) reads back its three fields at [21:16], [15:12] and [11:0]. All other bits read 0.
- R5: A write to index 4 with bit 0 set, while idle, starts a sense. Busy is then high for exactly 2*(relax+1)+read_strobe+1 cycles. When busy falls, read data (index 5) holds the addressed word.
- R6: A write to index 6 while idle and with key 0x3E77 starts a burn of the written value into the addressed word. Busy is then high for exactly 2*(relax+1)+program_strobe+1 cycles.
- R7: A burn ORs into the stored word. Bits already at 1 stay 1, and burning 0 leaves the word unchanged.
- R8: A write to index 6 while idle with any key other than 0x3E77 sets the error flag. It starts no operation and leaves the fuse store unchanged.
- R9: Any start request (index 4 with bit 0 set, or index 6) while busy sets the error flag. The running operation continues with its length unchanged, and no second operation starts. This includes a request in the last busy cycle.
- R10: The key field returns to 0 when a burn completes.
- R11: Address value bank*8+word selects one word. A burn at one address leaves the other addresses unchanged.
- R12: A write to index 4 with bit 0 clear starts nothing and sets no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr` (combinational) |

## Verification
A start request can arrive in the same cycle that the running operation finishes. The block then sees both the request and the completion in one cycle. The bench lines up a sense trigger exactly on the last busy cycle. It expects an error with no new operation, and then a normal start one cycle later. A burn completing also clears the key in the same cycle that software may be polling or rewriting control. The cycle-by-cycle model predicts every read of the register bus, and any disagreement in the busy, error or key bits is reported.

// File: rtl/fuse_pkg.sv
// Shared constants and types for the fuse word controller.
// Assumes a 32-bit register bus addressed by word index.
package fuse_pkg;
    localparam int REG_AW   = 3;
    localparam int DATA_W   = 32;
    localparam int RELAX_W  = 4;
    localparam int SREAD_W  = 6;
    localparam int SPROG_W  = 12;
    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

    localparam logic [REG_AW-1:0] IDX_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] IDX_SET    = 3'd1;
    localparam logic [REG_AW-1:0] IDX_CLR    = 3'd2;
    localparam logic [REG_AW-1:0] IDX_TIMING = 3'd3;
    localparam logic [REG_AW-1:0] IDX_TRIG   = 3'd4;
    localparam logic [REG_AW-1:0] IDX_RDATA  = 3'd5;
    localparam logic [REG_AW-1:0] IDX_WDATA  = 3'd6;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;
endpackage

// File: rtl/fuse_seq.sv
// Phase sequencer: setup (relax+1), strobe (strobe+1), hold (relax+1) cycles.
// Assumes start is only raised while idle; the lengths are latched at start.
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int CNT_W = SPROG_W,
    parameter int RLX_W = RELAX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RLX_W-1:0] relax,
    input  logic [CNT_W-1:0] strobe,
    output logic             busy,
    output logic             strobe_end,
    output logic             op_end
);
    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] stb_q;
    logic [RLX_W-1:0] rlx_q;

    // Advance the phase counter and move between phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            stb_q   <= '0;
            rlx_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= PH_SETUP;
                    cnt_q   <= CNT_W'(relax);
                    rlx_q   <= relax;
                    stb_q   <= strobe;
                end
                PH_SETUP: if (cnt_q == '0) begin
                    phase_q <= PH_STROBE;
                    cnt_q   <= stb_q;
                end else cnt_q <= cnt_q - 1'b1;
                PH_STROBE: if (cnt_q == '0) begin
                    phase_q <= PH_HOLD;
                    cnt_q   <= CNT_W'(rlx_q);
                end else cnt_q <= cnt_q - 1'b1;
                PH_HOLD: if (cnt_q == '0) phase_q <= PH_IDLE;
                         else cnt_q <= cnt_q - 1'b1;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Decode phase outputs.
    always_comb begin
        busy       = (phase_q != PH_IDLE);
        strobe_end = (phase_q == PH_STROBE) && (cnt_q == '0);
        op_end     = (phase_q == PH_HOLD) && (cnt_q == '0);
    end
endmodule

// File: rtl/fuse_store.sv
// Behavioural fuse store: each word can only gain 1 bits; blank after reset.
// Assumes addr is below WORDS.
module fuse_store #(
    parameter int WORDS = 32,
    parameter int AW    = 5,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wr_bits,
    output logic [DW-1:0]     rd_word,
    output logic [WORDS*DW-1:0] image
);
    logic [DW-1:0] word_q [WORDS];

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        // Burn: OR the new bits into word k.
        always_ff @(posedge clk) begin
            if (!rst_n)                               word_q[k] <= '0;
            else if (wr_en && (addr == AW'(k)))       word_q[k] <= word_q[k] | wr_bits;
        end
        assign image[k*DW +: DW] = word_q[k];
    end

    assign rd_word = word_q[addr];
endmodule

// File: rtl/fuse_word_ctrl.sv
// Register front end for sensing and burning single fuse words.
// Assumes one bus write per cycle; reads are combinational on bus_addr.
module fuse_word_ctrl
    import fuse_pkg::*;
#(
    parameter int NUM_BANKS      = 4,
    parameter int WORDS_PER_BANK = 8,
    parameter int RELAX_RST      = 1,
    parameter int SREAD_RST      = 6,
    parameter int SPROG_RST      = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [REG_AW-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata
);
    localparam int WSEL_W    = $clog2(WORDS_PER_BANK);
    localparam int BSEL_W    = $clog2(NUM_BANKS);
    localparam int FA_W      = BSEL_W + WSEL_W;
    localparam int NUM_WORDS = NUM_BANKS * WORDS_PER_BANK;
    localparam int IMG_W     = NUM_WORDS * DATA_W;

    logic [15:0]        key_q;
    logic [FA_W-1:0]    addr_q;
    logic               err_q;
    logic [RELAX_W-1:0] relax_q;
    logic [SREAD_W-1:0] sread_q;
    logic [SPROG_W-1:0] sprog_q;
    logic [DATA_W-1:0]  rd_q;
    logic [FA_W-1:0]    op_addr_q;
    logic [DATA_W-1:0]  op_data_q;
    logic               op_prog_q;

    logic seq_busy, strobe_end, op_end;
    logic trig_req, prog_req, key_ok, start_rd, start_pg, err_set;
    logic [SPROG_W-1:0] strobe_sel;
    logic [DATA_W-1:0]  rd_word;
    logic [IMG_W-1:0]   fuse_image;

    // Decode start requests and illegal accesses.
    always_comb begin
        trig_req   = bus_wr && (bus_addr == IDX_TRIG) && bus_wdata[0];
        prog_req   = bus_wr && (bus_addr == IDX_WDATA);
        key_ok     = (key_q == UNLOCK_KEY);
        start_rd   = trig_req && !seq_busy;
        start_pg   = prog_req && !seq_busy && key_ok;
        err_set    = ((trig_req || prog_req) && seq_busy) || (prog_req && !seq_busy && !key_ok);
        strobe_sel = start_pg ? sprog_q : SPROG_W'(sread_q);
    end

    // Control fields: key, address and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '0;
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (op_end && op_prog_q) key_q <= '0;
            if (bus_wr) begin
                unique case (bus_addr)
                    IDX_CTRL: begin
                        key_q  <= bus_wdata[31:16];
                        addr_q <= bus_wdata[FA_W-1:0];
                    end
                    IDX_SET: begin
                        key_q  <= key_q | bus_wdata[31:16];
                        addr_q <= addr_q | bus_wdata[FA_W-1:0];
                    end
                    IDX_CLR: begin
                        key_q  <= key_q & ~bus_wdata[31:16];
                        addr_q <= addr_q & ~bus_wdata[FA_W-1:0];
                    end
                    default: ;
                endcase
            end
            if (err_set) err_q <= 1'b1;
            else if (bus_wr && (bus_addr == IDX_CLR) && bus_wdata[9]) err_q <= 1'b0;
        end
    end

    // Timing fields, reset to non-zero defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            relax_q <= RELAX_W'(RELAX_RST);
            sread_q <= SREAD_W'(SREAD_RST);
            sprog_q <= SPROG_W'(SPROG_RST);
        end else if (bus_wr && (bus_addr == IDX_TIMING)) begin
            sread_q <= bus_wdata[21:16];
            relax_q <= bus_wdata[15:12];
            sprog_q <= bus_wdata[11:0];
        end
    end

    // Latch the operation target at start; capture sensed data at strobe end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr_q <= '0;
            op_data_q <= '0;
            op_prog_q <= 1'b0;
            rd_q      <= '0;
        end else begin
            if (start_rd || start_pg) begin
                op_addr_q <= addr_q;
                op_data_q <= bus_wdata;
                op_prog_q <= start_pg;
            end
            if (strobe_end && !op_prog_q) rd_q <= rd_word;
        end
    end

    fuse_seq #(.CNT_W(SPROG_W), .RLX_W(RELAX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_rd || start_pg),
        .relax      (relax_q),
        .strobe     (strobe_sel),
        .busy       (seq_busy),
        .strobe_end (strobe_end),
        .op_end     (op_end)
    );

    fuse_store #(.WORDS(NUM_WORDS), .AW(FA_W), .DW(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (strobe_end && op_prog_q),
        .addr    (op_addr_q),
        .wr_bits (op_data_q),
        .rd_word (rd_word),
        .image   (fuse_image)
    );

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            IDX_CTRL, IDX_SET, IDX_CLR: begin
                bus_rdata[31:16]    = key_q;
                bus_rdata[9]        = err_q;
                bus_rdata[8]        = seq_busy;
                bus_rdata[FA_W-1:0] = addr_q;
            end
            IDX_TIMING: bus_rdata = {10'b0, sread_q, relax_q, sprog_q};
            IDX_RDATA:  bus_rdata = rd_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fuse_word_ctrl_chk.sv
// Property checker for fuse_word_ctrl, attached by bind.
// Assumes it sees the controller's registers and sequencer busy.
module fuse_word_ctrl_chk
    import fuse_pkg::*;
#(
    parameter int IMG_W = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              busy,
    input logic              err,
    input logic [15:0]       key,
    input logic              op_prog,
    input logic [RELAX_W-1:0] relax,
    input logic [SREAD_W-1:0] sread,
    input logic [SPROG_W-1:0] sprog,
    input logic [IMG_W-1:0]  image
);
    logic        prev_busy;
    logic [15:0] run_cnt;
    logic [15:0] exp_len;

    // Measure each busy window and record the length it should have.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_busy <= 1'b0;
            run_cnt   <= '0;
            exp_len   <= '0;
        end else begin
            prev_busy <= busy;
            if (busy && !prev_busy) begin
                run_cnt <= 16'd1;
                exp_len <= 16'd2 * (16'(relax) + 16'd1) + 16'd1 +
                           (op_prog ? 16'(sprog) : 16'(sread));
            end else if (busy) begin
                run_cnt <= run_cnt + 16'd1;
            end
        end
    end

    assert_start_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && ((bus_addr == IDX_TRIG && bus_wdata[0]) || bus_addr == IDX_WDATA)));

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_busy && !busy) |-> (run_cnt == exp_len));

    assert_fuse_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(image) & ~image) == '0));

    assert_bad_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IDX_WDATA && !busy && key != UNLOCK_KEY) |=> (err && !busy));

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && busy && (bus_addr == IDX_WDATA || (bus_addr == IDX_TRIG && bus_wdata[0]))) |=> err);

    assert_key_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_prog && !$past(bus_wr && (bus_addr == IDX_CTRL || bus_addr == IDX_SET)))
        |-> (key == 16'h0000));
endmodule

bind fuse_word_ctrl fuse_word_ctrl_chk #(.IMG_W(IMG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (seq_busy),
    .err       (err_q),
    .key       (key_q),
    .op_prog   (op_prog_q),
    .relax     (relax_q),
    .sread     (sread_q),
    .sprog     (sprog_q),
    .image     (fuse_image)
);

// File: tb/fuse_word_ctrl_test.sv
module fuse_word_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int tests = 0;
    int fails = 0;
    logic [31:0] last_rd;

    // Reference model state.
    logic [15:0] m_key;
    logic [4:0]  m_addr;
    logic        m_err;
    int          m_rem, m_el, m_upd;
    logic        m_prog;
    logic [4:0]  m_opaddr;
    logic [31:0] m_opdata;
    logic [3:0]  m_relax;
    logic [5:0]  m_sr;
    logic [11:0] m_sp;
    logic [31:0] m_rd;
    logic [31:0] m_fuse [32];

    always #2 clk = ~clk;

    fuse_word_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0, 3'd1, 3'd2: return {m_key, 6'b0, m_err, (m_rem > 0), 3'b0, m_addr};
            3'd3: return {10'b0, m_sr, m_relax, m_sp};
            3'd5: return m_rd;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0, 3'd1, 3'd2: return "R2 per-cycle control";
            3'd3: return "R4 per-cycle timing";
            3'd5: return "R5 per-cycle read data";
            default: return "R1 per-cycle other";
        endcase
    endfunction

    task automatic model_reset();
        m_key = '0; m_addr = '0; m_err = 0; m_rem = 0; m_el = 0; m_upd = 0;
        m_prog = 0; m_opaddr = '0; m_opdata = '0; m_rd = '0;
        m_relax = 4'd1; m_sr = 6'd6; m_sp = 12'd20;
        for (int i = 0; i < 32; i++) m_fuse[i] = '0;
    endtask

    // Effect of one rising edge under the currently driven inputs.
    task automatic model_step();
        bit was_busy = (m_rem > 0);
        bit start;
        int stb;
        if (was_busy) begin
            m_el++;
            if (m_el == m_upd) begin
                if (m_prog) m_fuse[m_opaddr] = m_fuse[m_opaddr] | m_opdata;
                else        m_rd = m_fuse[m_opaddr];
            end
            m_rem--;
            if (m_rem == 0 && m_prog) m_key = '0;
        end
        if (bus_wr) begin
            start = 0;
            case (bus_addr)
                3'd0: begin m_key = bus_wdata[31:16]; m_addr = bus_wdata[4:0]; end
                3'd1: begin m_key |= bus_wdata[31:16]; m_addr |= bus_wdata[4:0]; end
                3'd2: begin
                    m_key &= ~bus_wdata[31:16]; m_addr &= ~bus_wdata[4:0];
                    if (bus_wdata[9]) m_err = 0;
                end
                3'd4: if (bus_wdata[0]) begin
                    if (was_busy) m_err = 1;
                    else begin start = 1; m_prog = 0; stb = int'(m_sr); end
                end
                3'd6: begin
                    if (was_busy || m_key != 16'h3E77) m_err = 1;
                    else begin start = 1; m_prog = 1; stb = int'(m_sp); end
                end
                default: ;
            endcase
            if (start) begin
                m_rem = 2 * (int'(m_relax) + 1) + stb + 1;
                m_upd = int'(m_relax) + stb + 2;
                m_el = 0;
                m_opaddr = m_addr;
                m_opdata = bus_wdata;
            end
            if (bus_addr == 3'd3) begin
                m_sr = bus_wdata[21:16]; m_relax = bus_wdata[15:12]; m_sp = bus_wdata[11:0];
            end
        end
    endtask

    // One clock: compare at the falling edge, step the model, pass the rising edge.
    task automatic cyc();
        @(negedge clk);
        last_rd = bus_rdata;
        if (rst_n) check(tag_of(bus_addr), bus_rdata, model_read(bus_addr));
        if (rst_n) model_step();
        @(posedge clk);
        #0.5;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 0; bus_addr = 3'd0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        cyc();
        v = last_rd;
        bus_addr = 3'd0;
    endtask

    task automatic busy_run(output int n);
        n = 0;
        forever begin
            bus_addr = 3'd0;
            cyc();
            if (last_rd[8]) n++;
            else break;
        end
    endtask

    task automatic sense(input logic [4:0] a, output logic [31:0] v, output int n);
        wr(3'd0, {27'b0, a});
        wr(3'd4, 32'h1);
        busy_run(n);
        rd(3'd5, v);
    endtask

    task automatic burn(input logic [4:0] a, input logic [31:0] d, output int n);
        wr(3'd0, {16'h3E77, 11'b0, a});
        wr(3'd6, d);
        busy_run(n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        model_reset();
        repeat (3) @(posedge clk);
        #0.5;
        rst_n = 1;

        // R1 reset state
        rd(3'd0, v); check("R1 control", v, 32'h0);
        rd(3'd3, v); check("R1 timing", v, 32'h0006_1014);
        rd(3'd5, v); check("R1 read data", v, 32'h0);

        // R2 plain write and set alias, status bits not writable
        wr(3'd0, 32'hFFFF_031F);
        rd(3'd0, v); check("R2 plain write", v, 32'hFFFF_001F);
        wr(3'd0, 32'h0000_0004);
        wr(3'd1, 32'h00A0_0301);
        rd(3'd1, v); check("R2 set alias", v, 32'h00A0_0005);
        // R3 clear alias
        wr(3'd0, 32'hFFFF_001F);
        wr(3'd2, 32'hFFF0_0010);
        rd(3'd0, v); check("R3 clear alias", v, 32'h000F_000F);

        // R4 timing layout
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v); check("R4 timing mask", v, 32'h003F_FFFF);
        wr(3'd3, 32'h0003_1005);
        rd(3'd3, v); check("R4 timing fields", v, 32'h0003_1005);

        // R5 sense of blank word
        sense(5'h0A, v, n);
        check("R5 sense busy length", n, 8);
        check("R5 blank word", v, 32'h0);

        // R12 trigger with bit 0 clear
        wr(3'd4, 32'hFFFF_FFFE);
        rd(3'd0, v); check("R12 no start no error", v[9:8], 2'b00);

        // R8 wrong key
        wr(3'd0, 32'h1234_000A);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R8 error set not busy", v[9:8], 2'b10);
        sense(5'h0A, v, n); check("R8 store unchanged", v, 32'h0);
        wr(3'd2, 32'h0000_0200);
        rd(3'd0, v); check("R3 error cleared", v[9], 1'b0);

        // R6 burn, R10 key clears
        burn(5'h0A, 32'h0000_F00F, n);
        check("R6 burn busy length", n, 10);
        rd(3'd0, v); check("R10 key cleared", v[31:16], 16'h0);
        sense(5'h0A, v, n); check("R6 burned value", v, 32'h0000_F00F);
        // R11 neighbour untouched, far address works
        sense(5'h0B, v, n); check("R11 neighbour blank", v, 32'h0);
        burn(5'h1F, 32'h8000_0001, n);
        sense(5'h1F, v, n); check("R11 bank 3 word 7", v, 32'h8000_0001);

        // R7 OR behaviour
        burn(5'h0A, 32'h00FF_0000, n);
        sense(5'h0A, v, n); check("R7 accumulate", v, 32'h00FF_F00F);
        burn(5'h0A, 32'h0, n);
        sense(5'h0A, v, n); check("R7 zero burn no change", v, 32'h00FF_F00F);

        // R9 start during burn: error, operation length unchanged
        wr(3'd0, {16'h3E77, 16'h0003});
        wr(3'd6, 32'h0000_0030);
        cyc(); cyc();
        wr(3'd4, 32'h1);
        busy_run(n);
        check("R9 burn continues", n + 3, 10);
        rd(3'd0, v); check("R9 error set", v[9], 1'b1);
        wr(3'd2, 32'h0000_0200);
        sense(5'h03, v, n); check("R9 burn landed", v, 32'h0000_0030);

        // R9 request on the last busy cycle
        wr(3'd4, 32'h1);
        repeat (7) cyc();
        wr(3'd4, 32'h1);
        rd(3'd0, v); check("R9 last-cycle start rejected", v[9:8], 2'b10);
        wr(3'd2, 32'h0000_0200);
        wr(3'd4, 32'h1);
        busy_run(n);
        check("R5 start after idle", n, 8);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule